// File: doc/BRIEF.md
# Programmable-Slot Interrupt Priority Resolver

This block takes pending interrupt requests from three groups of peripheral sources and reduces them, once per clock, to one registered winner: a valid flag, the winning priority level and the identity of the source behind it. Sixteen general sources hold fixed places in a 32-level priority table. Fixed source 0 is the direct-memory bus-error source and always holds level 0. The communication-controller sources have no fixed place. Five fast/multichannel sources are steered into eight X slots, and four serial sources are steered into eight Y slots. A per-source mapping field chooses the slot, and software may rewrite it on any cycle, for example to rotate priority.

A layout input chooses between two places for the eight Y slots in the table. In group mode they sit together directly below the bus-error source. In spread mode they are interleaved with the fixed sources: one Y slot follows every second fixed source, and any Y slots left over go at the bottom of the table. A lower level number always means higher priority.

Top module: `pfx_irq_resolver`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs clear to zero, every mapping field reads as unmapped, and the layout returns to group mode.
- R2: The output reports the lowest-numbered level whose request is pending and unmasked. It is registered, so a request present before a rising edge is reported just after that edge.
- R3: A mask bit of 1 blocks its source. With every source blocked or idle, `irq_valid` is 0.
- R4: Fast source j uses field `x_map[4j+3:4j]`. Bit 3 set means mapped, and bits 2:0 select X slot 0 to 7. A source whose bit 3 is clear never wins.
- R5: Serial source j uses field `y_map[4j+3:4j]` with the same encoding for the Y slots. A source whose bit 3 is clear never wins.
- R6: When several sources of one family are mapped to the same slot, the lowest-indexed of them owns that slot. The others cannot win through it, even while the owner is idle.
- R7: In group mode (`spread_mode`=0), the levels are: fixed 0 at level 0, Y slot k at 1+k, X slot s at 9+s, and fixed i (i≥1) at 16+i.
- R8: In spread mode (`spread_mode`=1), fixed 0 is at level 0 and X slot s is at 1+s. Fixed sources 1 to 15 follow in order, with Y slot k placed directly after fixed source 2(k+1) while that source exists. The remaining Y slots are placed after fixed 15. For example, fixed 1 is at 9, Y slot 0 at 11, Y slot 6 at 29 and Y slot 7 at 31.
- R9: A change to `x_map`, `y_map` or `spread_mode` is captured at one rising edge. It governs the result produced at the following edge.
- R10: An unmasked request from fixed source 0 always wins, at level 0, in either layout.
- R11: When `irq_valid` is 0, `irq_level` and `irq_src` are 0.
- R12: `irq_src` numbers the fixed sources 0 to 15, the fast sources 16 to 20 and the serial sources 21 to 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fix_req | input | 16 | Requests from the fixed sources |
| fix_mask | input | 16 | Masks for the fixed sources (1 = blocked) |
| x_req | input | 5 | Requests from the fast/multichannel sources |
| x_mask | input | 5 | Masks for the fast sources |
| y_req | input | 4 | Requests from the serial sources |
| y_mask | input | 4 | Masks for the serial sources |
| x_map | input | 20 | Per-fast-source mapping fields {mapped, slot[2:0]} |
| y_map | input | 16 | Per-serial-source mapping fields {mapped, slot[2:0]} |
| spread_mode | input | 1 | Y-slot layout: 0 group, 1 spread |
| irq_valid | output | 1 | A winner is reported |
| irq_level | output | 5 | Level of the winner |
| irq_src | output | 5 | Source identity of the winner |

## Verification
The assertions assume that the request and mask inputs are held at zero while reset is applied, so the one-cycle pending history they compare against starts clean. They also assume every mapping field is either clear or names a slot in range, which the 3-bit slot field guarantees. The bench drives every input on the falling edge. It holds the mapping and layout for at least two rising edges before it compares against its table model, and it changes configuration at the same instant as the requests only in the latency scenario.

// File: rtl/pfx_pkg.sv
// Package: shared sizes and the level-placement functions of the resolver.
// Assumes both slot families have the same slot count (power of two).
package pfx_pkg;
    localparam int NFIX       = 16;
    localparam int NXSRC      = 5;
    localparam int NYSRC      = 4;
    localparam int NXSLOT     = 8;
    localparam int NYSLOT     = 8;
    localparam int SPREAD_GAP = 2;

    localparam int SLW   = $clog2(NXSLOT);
    localparam int MFW   = SLW + 1;
    localparam int NLVL  = NFIX + NXSLOT + NYSLOT;
    localparam int LVLW  = $clog2(NLVL);
    localparam int NSRC  = NFIX + NXSRC + NYSRC;
    localparam int SRCW  = $clog2(NSRC);
    localparam int XIDW  = (NXSRC > 1) ? $clog2(NXSRC) : 1;
    localparam int YIDW  = (NYSRC > 1) ? $clog2(NYSRC) : 1;

    // Level of fixed source i in the selected layout.
    function automatic int lvl_fix(input int i, input bit spread);
        int ybefore;
        if (i == 0) return 0;
        if (!spread) return 1 + NYSLOT + NXSLOT + (i - 1);
        ybefore = (i - 1) / SPREAD_GAP;
        if (ybefore > NYSLOT) ybefore = NYSLOT;
        return 1 + NXSLOT + (i - 1) + ybefore;
    endfunction

    // Level of X slot s in the selected layout.
    function automatic int lvl_x(input int s, input bit spread);
        return spread ? 1 + s : 1 + NYSLOT + s;
    endfunction

    // Level of Y slot k in the selected layout.
    function automatic int lvl_y(input int k, input bit spread);
        int pos;
        if (!spread) return 1 + k;
        pos = (k + 1) * SPREAD_GAP;
        if (pos <= NFIX - 1) return 1 + NXSLOT + pos + k;
        return 1 + NXSLOT + (NFIX - 1) + k;
    endfunction
endpackage

// File: rtl/pfx_slot_map.sv
// Slot ownership for one family: each slot is owned by the lowest-indexed
// source mapped to it; the slot is pending when its owner is pending and
// unmasked. Assumes map fields are {mapped, slot}.
module pfx_slot_map #(
    parameter int NS    = 5,
    parameter int NSLOT = 8,
    parameter int FW    = 4,
    parameter int IDXW  = 3
) (
    input  logic [NS-1:0]                req,
    input  logic [NS-1:0]                mask,
    input  logic [NS*FW-1:0]             map,
    output logic [NSLOT-1:0]             slot_hit,
    output logic [NSLOT-1:0][IDXW-1:0]   slot_owner
);
    localparam int SW = FW - 1;

    logic [NSLOT-1:0] owned;

    // Scan sources high to low so the lowest mapped index remains as owner.
    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            slot_owner[s] = '0;
            owned[s]      = 1'b0;
            for (int j = NS - 1; j >= 0; j--) begin
                if (map[j*FW + SW] && (map[j*FW +: SW] == SW'(s))) begin
                    slot_owner[s] = IDXW'(j);
                    owned[s]      = 1'b1;
                end
            end
            slot_hit[s] = owned[s] & req[slot_owner[s]] & ~mask[slot_owner[s]];
        end
    end
endmodule

// File: rtl/pfx_order_table.sv
// Arranges fixed, X-slot and Y-slot pending bits into level order for both
// layouts and selects one by the layout flag; also carries source identity.
// Assumes the level functions form a permutation of 0..NLVL-1.
module pfx_order_table
    import pfx_pkg::*;
(
    input  logic [NFIX-1:0]               fix_pend,
    input  logic [NXSLOT-1:0]             x_hit,
    input  logic [NXSLOT-1:0][XIDW-1:0]   x_owner,
    input  logic [NYSLOT-1:0]             y_hit,
    input  logic [NYSLOT-1:0][YIDW-1:0]   y_owner,
    input  logic                          spread,
    output logic [NLVL-1:0]               ord_req,
    output logic [NLVL-1:0][SRCW-1:0]     ord_src
);
    logic [NLVL-1:0]           grp_req, spr_req;
    logic [NLVL-1:0][SRCW-1:0] grp_src, spr_src;

    // Place fixed sources.
    for (genvar i = 0; i < NFIX; i++) begin : g_fix
        localparam int GL = lvl_fix(i, 1'b0);
        localparam int SL = lvl_fix(i, 1'b1);
        assign grp_req[GL] = fix_pend[i];
        assign spr_req[SL] = fix_pend[i];
        assign grp_src[GL] = SRCW'(i);
        assign spr_src[SL] = SRCW'(i);
    end

    // Place X slots.
    for (genvar s = 0; s < NXSLOT; s++) begin : g_x
        localparam int GL = lvl_x(s, 1'b0);
        localparam int SL = lvl_x(s, 1'b1);
        assign grp_req[GL] = x_hit[s];
        assign spr_req[SL] = x_hit[s];
        assign grp_src[GL] = SRCW'(NFIX) + SRCW'(x_owner[s]);
        assign spr_src[SL] = SRCW'(NFIX) + SRCW'(x_owner[s]);
    end

    // Place Y slots.
    for (genvar k = 0; k < NYSLOT; k++) begin : g_y
        localparam int GL = lvl_y(k, 1'b0);
        localparam int SL = lvl_y(k, 1'b1);
        assign grp_req[GL] = y_hit[k];
        assign spr_req[SL] = y_hit[k];
        assign grp_src[GL] = SRCW'(NFIX + NXSRC) + SRCW'(y_owner[k]);
        assign spr_src[SL] = SRCW'(NFIX + NXSRC) + SRCW'(y_owner[k]);
    end

    // Layout select.
    assign ord_req = spread ? spr_req : grp_req;
    assign ord_src = spread ? spr_src : grp_src;
endmodule

// File: rtl/pfx_lowest_first.sv
// Finds the lowest set bit of a vector. Assumes W is at least 2.
module pfx_lowest_first #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan high to low so the lowest set index is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pfx_irq_resolver.sv
// Top: registers the mapping/layout inputs, resolves slot ownership per
// family, orders all pending entries by level and registers the winner.
// Assumes synchronous active-low reset; one cycle from request to output.
module pfx_irq_resolver
    import pfx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NFIX-1:0]        fix_req,
    input  logic [NFIX-1:0]        fix_mask,
    input  logic [NXSRC-1:0]       x_req,
    input  logic [NXSRC-1:0]       x_mask,
    input  logic [NYSRC-1:0]       y_req,
    input  logic [NYSRC-1:0]       y_mask,
    input  logic [NXSRC*MFW-1:0]   x_map,
    input  logic [NYSRC*MFW-1:0]   y_map,
    input  logic                   spread_mode,
    output logic                   irq_valid,
    output logic [LVLW-1:0]        irq_level,
    output logic [SRCW-1:0]        irq_src
);
    logic [NXSRC*MFW-1:0]         x_map_q;
    logic [NYSRC*MFW-1:0]         y_map_q;
    logic                         spread_q;
    logic [NXSLOT-1:0]            x_hit;
    logic [NXSLOT-1:0][XIDW-1:0]  x_owner;
    logic [NYSLOT-1:0]            y_hit;
    logic [NYSLOT-1:0][YIDW-1:0]  y_owner;
    logic [NLVL-1:0]              ord_req;
    logic [NLVL-1:0][SRCW-1:0]    ord_src;
    logic                         win_found;
    logic [LVLW-1:0]              win_lvl;

    // Capture the configuration so a write governs the next decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_map_q  <= '0;
            y_map_q  <= '0;
            spread_q <= 1'b0;
        end else begin
            x_map_q  <= x_map;
            y_map_q  <= y_map;
            spread_q <= spread_mode;
        end
    end

    pfx_slot_map #(.NS(NXSRC), .NSLOT(NXSLOT), .FW(MFW), .IDXW(XIDW)) u_xmap (
        .req(x_req), .mask(x_mask), .map(x_map_q),
        .slot_hit(x_hit), .slot_owner(x_owner)
    );

    pfx_slot_map #(.NS(NYSRC), .NSLOT(NYSLOT), .FW(MFW), .IDXW(YIDW)) u_ymap (
        .req(y_req), .mask(y_mask), .map(y_map_q),
        .slot_hit(y_hit), .slot_owner(y_owner)
    );

    pfx_order_table u_order (
        .fix_pend(fix_req & ~fix_mask),
        .x_hit(x_hit), .x_owner(x_owner),
        .y_hit(y_hit), .y_owner(y_owner),
        .spread(spread_q),
        .ord_req(ord_req), .ord_src(ord_src)
    );

    pfx_lowest_first #(.W(NLVL), .IW(LVLW)) u_pick (
        .vec(ord_req), .found(win_found), .idx(win_lvl)
    );

    // Register the winner; report zeros when nothing is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_level <= '0;
            irq_src   <= '0;
        end else begin
            irq_valid <= win_found;
            irq_level <= win_found ? win_lvl : '0;
            irq_src   <= win_found ? ord_src[win_lvl] : '0;
        end
    end
endmodule

// File: rtl/pfx_irq_resolver_chk.sv
// Checker: temporal properties of the resolver, bound to every instance.
// Assumes requests and masks are zero while reset is applied.
module pfx_irq_resolver_chk
    import pfx_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [NFIX-1:0]        fix_req,
    input logic [NFIX-1:0]        fix_mask,
    input logic [NXSRC-1:0]       x_req,
    input logic [NXSRC-1:0]       x_mask,
    input logic [NYSRC-1:0]       y_req,
    input logic [NYSRC-1:0]       y_mask,
    input logic [NXSRC*MFW-1:0]   x_map,
    input logic [NYSRC*MFW-1:0]   y_map,
    input logic                   spread_mode,
    input logic                   irq_valid,
    input logic [LVLW-1:0]        irq_level,
    input logic [SRCW-1:0]        irq_src
);
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] pend_d;

    assign pend = {y_req & ~y_mask, x_req & ~x_mask, fix_req & ~fix_mask};

    // One-cycle history of pending sources, indexed by source identity.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_d <= '0;
        else        pend_d <= pend;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !irq_valid && irq_level == '0 && irq_src == '0);

    p_winner_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> pend_d[irq_src]);

    p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> !irq_valid);

    p_buserr_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0] |=> irq_valid && irq_level == '0 && irq_src == '0);

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> irq_level == '0 && irq_src == '0);

    p_src_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> int'(irq_src) < NSRC);
endmodule

bind pfx_irq_resolver pfx_irq_resolver_chk chk_i (.*);

// File: tb/pfx_irq_resolver_tb_top.sv
`timescale 1ns/1ps
module pfx_irq_resolver_tb_top;
    import pfx_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [NFIX-1:0]       fix_req, fix_mask;
    logic [NXSRC-1:0]      x_req, x_mask;
    logic [NYSRC-1:0]      y_req, y_mask;
    logic [NXSRC*MFW-1:0]  x_map;
    logic [NYSRC*MFW-1:0]  y_map;
    logic                  spread_mode;
    logic                  irq_valid;
    logic [LVLW-1:0]       irq_level;
    logic [SRCW-1:0]       irq_src;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pfx_irq_resolver dut_i (
        .clk(clk), .rst_n(rst_n),
        .fix_req(fix_req), .fix_mask(fix_mask),
        .x_req(x_req), .x_mask(x_mask),
        .y_req(y_req), .y_mask(y_mask),
        .x_map(x_map), .y_map(y_map), .spread_mode(spread_mode),
        .irq_valid(irq_valid), .irq_level(irq_level), .irq_src(irq_src)
    );

    // ---- reference table: kind 0 fixed, 1 X slot, 2 Y slot ----
    int tk[NLVL];
    int ti[NLVL];

    function automatic void build_table(input bit spread);
        int n = 0;
        int yk = 0;
        tk[n] = 0; ti[n] = 0; n++;
        if (!spread) begin
            for (int k = 0; k < NYSLOT; k++) begin tk[n] = 2; ti[n] = k; n++; end
            for (int s = 0; s < NXSLOT; s++) begin tk[n] = 1; ti[n] = s; n++; end
            for (int i = 1; i < NFIX; i++)   begin tk[n] = 0; ti[n] = i; n++; end
        end else begin
            for (int s = 0; s < NXSLOT; s++) begin tk[n] = 1; ti[n] = s; n++; end
            for (int i = 1; i < NFIX; i++) begin
                tk[n] = 0; ti[n] = i; n++;
                if (i % SPREAD_GAP == 0 && yk < NYSLOT) begin
                    tk[n] = 2; ti[n] = yk; n++; yk++;
                end
            end
            while (yk < NYSLOT) begin tk[n] = 2; ti[n] = yk; n++; yk++; end
        end
    endfunction

    function automatic void model(output bit ev, output int el, output int es);
        ev = 0; el = 0; es = 0;
        build_table(spread_mode);
        for (int l = 0; l < NLVL; l++) begin
            int own = -1;
            bit hit = 0;
            int sid = 0;
            if (tk[l] == 0) begin
                hit = fix_req[ti[l]] && !fix_mask[ti[l]];
                sid = ti[l];
            end else if (tk[l] == 1) begin
                for (int j = NXSRC - 1; j >= 0; j--)
                    if (x_map[j*MFW+SLW] && int'(x_map[j*MFW +: SLW]) == ti[l]) own = j;
                if (own >= 0) begin
                    hit = x_req[own] && !x_mask[own];
                    sid = NFIX + own;
                end
            end else begin
                for (int j = NYSRC - 1; j >= 0; j--)
                    if (y_map[j*MFW+SLW] && int'(y_map[j*MFW +: SLW]) == ti[l]) own = j;
                if (own >= 0) begin
                    hit = y_req[own] && !y_mask[own];
                    sid = NFIX + NXSRC + own;
                end
            end
            if (hit) begin ev = 1; el = l; es = sid; return; end
        end
    endfunction

    // ---- checking helpers ----
    task automatic check_exp(input string tag, input bit ev, input int el, input int es);
        n_checks++;
        if (irq_valid !== ev || int'(irq_level) != el || int'(irq_src) != es) begin
            n_errors++;
            $display("FAIL %s: got valid=%0b level=%0d src=%0d, expected valid=%0b level=%0d src=%0d",
                     tag, irq_valid, irq_level, irq_src, ev, el, es);
        end
    endtask

    task automatic check_model(input string tag);
        bit ev; int el; int es;
        model(ev, el, es);
        check_exp(tag, ev, el, es);
    endtask

    task automatic settle();
        @(posedge clk); @(posedge clk); @(negedge clk);
    endtask

    task automatic clear_inputs();
        fix_req = '0; fix_mask = '0; x_req = '0; x_mask = '0;
        y_req = '0; y_mask = '0; x_map = '0; y_map = '0; spread_mode = 1'b0;
    endtask

    function automatic logic [MFW-1:0] fld(input int slot);
        return {1'b1, SLW'(slot)};
    endfunction

    // ---- scenarios ----
    task automatic t_reset();
        @(negedge clk);
        x_map[0 +: MFW] = fld(2); x_req[0] = 1'b1; spread_mode = 1'b1;
        settle();
        rst_n = 1'b0; x_req = '0;
        @(posedge clk); @(negedge clk);
        check_exp("R1 reset clears outputs", 0, 0, 0);
        rst_n = 1'b1; x_map = '0; spread_mode = 1'b0;
        settle();
        check_exp("R11 idle after reset", 0, 0, 0);
    endtask

    task automatic t_fixed_order();
        @(negedge clk); clear_inputs();
        fix_req[5] = 1'b1; fix_req[9] = 1'b1;
        @(posedge clk); @(negedge clk);
        check_exp("R2 one-cycle latency, fixed5 group level", 1, 21, 5);
        fix_req[5] = 1'b0;
        @(posedge clk); @(negedge clk);
        check_exp("R2 next lowest level wins", 1, 25, 9);
    endtask

    task automatic t_mask();
        @(negedge clk); clear_inputs();
        fix_req[3] = 1'b1; fix_req[7] = 1'b1; fix_mask[3] = 1'b1;
        settle();
        check_exp("R3 masked source skipped", 1, 23, 7);
        fix_mask[7] = 1'b1;
        settle();
        check_exp("R3 all masked gives no valid", 0, 0, 0);
    endtask

    task automatic t_x_map();
        @(negedge clk); clear_inputs();
        x_map[3*MFW +: MFW] = fld(5); x_req[3] = 1'b1; fix_req[1] = 1'b1;
        settle();
        check_exp("R4 X src3 in slot5 group", 1, 14, NFIX + 3);
        x_map[3*MFW +: MFW] = {1'b0, SLW'(5)};
        settle();
        check_exp("R4 unmapped X src never wins", 1, 17, 1);
    endtask

    task automatic t_y_map();
        @(negedge clk); clear_inputs();
        y_map[2*MFW +: MFW] = fld(3); y_req[2] = 1'b1; fix_req[2] = 1'b1;
        settle();
        check_exp("R5 Y src2 slot3 group", 1, 4, NFIX + NXSRC + 2);
        y_map[2*MFW +: MFW] = '0;
        settle();
        check_exp("R5 unmapped Y src never wins", 1, 18, 2);
    endtask

    task automatic t_shared_slot();
        @(negedge clk); clear_inputs();
        x_map[1*MFW +: MFW] = fld(4); x_map[4*MFW +: MFW] = fld(4);
        x_req[1] = 1'b1; x_req[4] = 1'b1;
        settle();
        check_exp("R6 lower index owns shared slot", 1, 13, NFIX + 1);
        x_req[1] = 1'b0;
        settle();
        check_exp("R6 shadowed source blocked while owner idle", 0, 0, 0);
        x_map[1*MFW +: MFW] = '0;
        settle();
        check_exp("R6 slot passes when owner unmapped", 1, 13, NFIX + 4);
    endtask

    task automatic t_layouts();
        @(negedge clk); clear_inputs();
        y_map[0 +: MFW] = fld(0); y_req[0] = 1'b1;
        settle();
        check_exp("R7 group Y slot0 level", 1, 1, NFIX + NXSRC);
        spread_mode = 1'b1;
        settle();
        check_exp("R8 spread Y slot0 level", 1, 11, NFIX + NXSRC);
        y_map[0 +: MFW] = fld(6);
        settle();
        check_exp("R8 spread Y slot6 level", 1, 29, NFIX + NXSRC);
        y_map[0 +: MFW] = fld(7);
        settle();
        check_exp("R8 spread Y slot7 at bottom", 1, 31, NFIX + NXSRC);
        y_req = '0; x_map[0 +: MFW] = fld(0); x_req[0] = 1'b1;
        settle();
        check_exp("R8 spread X slot0 level", 1, 1, NFIX);
        spread_mode = 1'b0;
        settle();
        check_exp("R7 group X slot0 level", 1, 9, NFIX);
    endtask

    task automatic t_latency();
        @(negedge clk); clear_inputs();
        y_map[0 +: MFW] = fld(0); y_req[0] = 1'b1; fix_req[1] = 1'b1;
        settle();
        check_exp("R9 group before switch", 1, 1, NFIX + NXSRC);
        spread_mode = 1'b1;
        @(posedge clk); @(negedge clk);
        check_exp("R9 old layout one edge after write", 1, 1, NFIX + NXSRC);
        @(posedge clk); @(negedge clk);
        check_exp("R9 new layout second edge", 1, 9, 1);
    endtask

    task automatic t_buserr();
        @(negedge clk); clear_inputs();
        y_map[0 +: MFW] = fld(0); y_req = '1; x_req = '1; fix_req = '1;
        settle();
        check_exp("R10 bus error wins group", 1, 0, 0);
        spread_mode = 1'b1;
        settle();
        check_exp("R10 bus error wins spread", 1, 0, 0);
    endtask

    task automatic t_random();
        @(negedge clk); clear_inputs();
        for (int n = 0; n < 300; n++) begin
            fix_req = NFIX'($urandom) & NFIX'($urandom);
            fix_mask = NFIX'($urandom) & NFIX'($urandom);
            x_req = NXSRC'($urandom); x_mask = NXSRC'($urandom) & NXSRC'($urandom);
            y_req = NYSRC'($urandom); y_mask = NYSRC'($urandom) & NYSRC'($urandom);
            x_map = (NXSRC*MFW)'($urandom); y_map = (NYSRC*MFW)'($urandom);
            spread_mode = 1'($urandom);
            settle();
            check_model("R2 R4 R5 R6 R12 random remap vs table");
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        clear_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_exp("R1 initial reset state", 0, 0, 0);
        rst_n = 1'b1;
        t_reset();
        t_fixed_order();
        t_mask();
        t_x_map();
        t_y_map();
        t_shared_slot();
        t_layouts();
        t_latency();
        t_buserr();
        t_random();
        finish_run();
    end
endmodule